// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit reduces the interrupt sources of a UART to one status word and one interrupt request line. There are four sources: receiver line errors, received data (either a FIFO fill level reached or a character timeout), transmit space available, and a change on a modem input. Each source has its own enable bit. When at least one enabled source is pending, the unit reports the most urgent one as a three-bit identifier.

The status word also carries two bytes. The line status byte holds sticky receive error flags next to live receiver and transmitter levels. The modem status byte holds sticky change flags next to the inverted, registered levels of the four modem inputs.

Reading the status word clears every sticky flag. If a flag is raised again in the same cycle as the read, the new event wins. The FIFOs and the register bus decode sit outside this unit: their request lines and a one-cycle read strobe arrive as inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: Status bit 0 is 0 and `irq_n` is 0 exactly when at least one enabled source is pending. Otherwise both are 1 and status bits 3:1 are 0.
- R2: Status bits 3:1 carry the identifier of the reported source: 3 for line error, 2 for receive level, 6 for character timeout, 1 for transmit space and 0 for modem change. No other code ever appears while bit 0 is 0.
- R3: Priority from highest to lowest is line error, then received data, then transmit space, then modem change. Within received data, a reached level (code 2) outranks a timeout (code 6).
- R4: `irq_en` bit 0 enables received data, bit 1 transmit space, bit 2 line error and bit 3 modem change. A disabled source has no effect on bits 3:0 or on `irq_n`.
- R5: Line status is status bits 23:16. Bit 16 is data ready, 17 overrun, 18 parity error, 19 framing error, 20 break, 21 holding register empty, 22 transmitter empty and 23 receive FIFO error. Bits 16, 21, 22 and 23 follow their inputs in the same cycle.
- R6: A one-cycle pulse on an error input sets its status bit from the following cycle on. The bit holds until a read cycle; when the read and a new pulse coincide, the bit stays set.
- R7: Status bits 15:12 show the inverted modem input levels sampled at the previous clock edge: 12 CTS, 13 DSR, 14 RI, 15 DCD. After reset, with all inputs 0, these bits read 1.
- R8: Status bits 11:8 are delta flags for CTS, DSR, RI and DCD, in that order. A flag is set in the cycle after its input changes and clears on a read, with a new change in the read cycle winning.
- R9: Status bits 7:4 always read 0. With all inputs 0 after reset, the status word is 0x00F001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 4 | Source enables: RX, TX, line error, modem |
| rx_level_hit | input | 1 | Receive FIFO reached its trigger level |
| rx_char_timeout | input | 1 | Receive character timeout |
| tx_space_hit | input | 1 | Transmit FIFO has space at its trigger level |
| rx_data_ready | input | 1 | Receive data present (level) |
| rx_overrun | input | 1 | Overrun error pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_frame_err | input | 1 | Framing error pulse |
| rx_break | input | 1 | Break detected pulse |
| tx_hold_empty | input | 1 | Transmit holding stage empty (level) |
| tx_shift_empty | input | 1 | Transmitter fully empty (level) |
| rx_fifo_err | input | 1 | Error present in receive FIFO (level) |
| modem_in | input | 4 | Modem inputs CTS, DSR, RI, DCD (bit 0 to 3) |
| status_rd | input | 1 | Status word read strobe; clears sticky flags |
| status_word | output | 24 | Pending flag, identifier, modem and line status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The encoder is swept over all sixteen enable masks crossed with all thirty-two combinations of the five source requests. That sweep separates the enable mapping from the priority ordering, and the level code from the timeout code. Each error input and each modem input is exercised on its own, which separates bit positions within both status bytes. Reads that coincide with new events separate "set wins" from "clear wins". A modem toggle that is read back confirms the one-cycle sampling delay and the inversion of the level bits.

// File: rtl/uir_pkg.sv
package uir_pkg;
  localparam int NUM_MODEM = 4;
  localparam int NUM_ERR   = 4;
  localparam int NUM_SRC   = 4;
  localparam int ID_W      = 3;
  localparam int STAT_W    = 24;

  // enable bit positions
  localparam int EN_RX  = 0;
  localparam int EN_TX  = 1;
  localparam int EN_LS  = 2;
  localparam int EN_MS  = 3;

  // identifier codes
  localparam logic [ID_W-1:0] ID_MODEM   = 3'd0;
  localparam logic [ID_W-1:0] ID_TXSPACE = 3'd1;
  localparam logic [ID_W-1:0] ID_RXLEVEL = 3'd2;
  localparam logic [ID_W-1:0] ID_LINEERR = 3'd3;
  localparam logic [ID_W-1:0] ID_TIMEOUT = 3'd6;

  typedef struct packed {
    logic line_err;
    logic rx_level;
    logic rx_tmo;
    logic tx_space;
    logic modem;
  } src_req_t;
endpackage

// File: rtl/uir_sticky_flags.sv
module uir_sticky_flags #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] flags_q, flags_d;

  // new events take precedence over a clearing read
  always_comb begin
    flags_d = clr_i ? set_i : (flags_q | set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/uir_modem_track.sv
module uir_modem_track #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] delta_o
);
  logic [WIDTH-1:0] level_q;
  logic [WIDTH-1:0] change;

  always_comb begin
    change = pins_i ^ level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= pins_i;
  end

  uir_sticky_flags #(.WIDTH(WIDTH)) u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (change),
    .clr_i   (clr_i),
    .flags_o (delta_o)
  );

  assign level_o = level_q;
endmodule

// File: rtl/uir_prio_enc.sv
module uir_prio_enc
  import uir_pkg::*;
(
  input  src_req_t              req_i,
  input  logic [NUM_SRC-1:0]    en_i,
  output logic [ID_W-1:0]       id_o,
  output logic                  pend_n_o
);
  logic ls_act, rx_act, tx_act, ms_act;

  always_comb begin
    ls_act = req_i.line_err & en_i[EN_LS];
    rx_act = (req_i.rx_level | req_i.rx_tmo) & en_i[EN_RX];
    tx_act = req_i.tx_space & en_i[EN_TX];
    ms_act = req_i.modem & en_i[EN_MS];
    pend_n_o = 1'b0;
    id_o     = ID_MODEM;
    if (ls_act)       id_o = ID_LINEERR;
    else if (rx_act)  id_o = req_i.rx_level ? ID_RXLEVEL : ID_TIMEOUT;
    else if (tx_act)  id_o = ID_TXSPACE;
    else if (ms_act)  id_o = ID_MODEM;
    else              pend_n_o = 1'b1;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uir_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_en,
  input  logic                 rx_level_hit,
  input  logic                 rx_char_timeout,
  input  logic                 tx_space_hit,
  input  logic                 rx_data_ready,
  input  logic                 rx_overrun,
  input  logic                 rx_parity_err,
  input  logic                 rx_frame_err,
  input  logic                 rx_break,
  input  logic                 tx_hold_empty,
  input  logic                 tx_shift_empty,
  input  logic                 rx_fifo_err,
  input  logic [NUM_MODEM-1:0] modem_in,
  input  logic                 status_rd,
  output logic [STAT_W-1:0]    status_word,
  output logic                 irq_n
);
  logic [NUM_ERR-1:0]   err_evt, err_q;
  logic [NUM_MODEM-1:0] mdm_lvl, mdm_dlt;
  src_req_t             req;
  logic [ID_W-1:0]      id;
  logic                 pend_n;
  logic [7:0]           line_byte, modem_byte;

  assign err_evt = {rx_break, rx_frame_err, rx_parity_err, rx_overrun};

  uir_sticky_flags #(.WIDTH(NUM_ERR)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (err_evt),
    .clr_i   (status_rd),
    .flags_o (err_q)
  );

  uir_modem_track #(.WIDTH(NUM_MODEM)) u_mdm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_i  (modem_in),
    .clr_i   (status_rd),
    .level_o (mdm_lvl),
    .delta_o (mdm_dlt)
  );

  always_comb begin
    req.line_err = |err_q;
    req.rx_level = rx_level_hit;
    req.rx_tmo   = rx_char_timeout;
    req.tx_space = tx_space_hit;
    req.modem    = |mdm_dlt;
  end

  uir_prio_enc u_enc (
    .req_i    (req),
    .en_i     (irq_en),
    .id_o     (id),
    .pend_n_o (pend_n)
  );

  always_comb begin
    line_byte  = {rx_fifo_err, tx_shift_empty, tx_hold_empty, err_q, rx_data_ready};
    modem_byte = {~mdm_lvl, mdm_dlt};
    status_word = {line_byte, modem_byte, 4'b0000, (pend_n ? 3'b000 : id), pend_n};
  end

  assign irq_n = pend_n;
endmodule

module uart_irq_ident_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  irq_en,
  input logic        rx_overrun,
  input logic [3:0]  modem_in,
  input logic        status_rd,
  input logic [23:0] status_word,
  input logic        irq_n
);
  assert_pending_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == status_word[0]);

  assert_legal_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !status_word[0] |-> (status_word[3:1] inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6}));

  assert_line_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[2] && |status_word[20:17]) |-> (!status_word[0] && status_word[3:1] == 3'd3));

  assert_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0000) |-> irq_n);

  assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> status_word[17]);

  assert_overrun_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !rx_overrun) |=> !status_word[17]);

  assert_modem_inverted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_word[15:12] == ~$past(modem_in)));

  assert_zero_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[7:4] == 4'b0000);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_en      (irq_en),
  .rx_overrun  (rx_overrun),
  .modem_in    (modem_in),
  .status_rd   (status_rd),
  .status_word (status_word),
  .irq_n       (irq_n)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  irq_en;
  logic        rx_level_hit, rx_char_timeout, tx_space_hit;
  logic        rx_data_ready, rx_overrun, rx_parity_err, rx_frame_err, rx_break;
  logic        tx_hold_empty, tx_shift_empty, rx_fifo_err;
  logic [3:0]  modem_in;
  logic        status_rd;
  logic [23:0] status_word;
  logic        irq_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .rx_level_hit(rx_level_hit), .rx_char_timeout(rx_char_timeout),
    .tx_space_hit(tx_space_hit), .rx_data_ready(rx_data_ready),
    .rx_overrun(rx_overrun), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break),
    .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
    .rx_fifo_err(rx_fifo_err), .modem_in(modem_in),
    .status_rd(status_rd), .status_word(status_word), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_read();
    status_rd = 1'b1;
    step();
    status_rd = 1'b0;
  endtask

  // expected {id, pending_n}
  function automatic logic [3:0] exp_low(input logic [3:0] en, input logic [4:0] s);
    logic ls, rx, tx, ms;
    ls = s[0] & en[2];
    rx = (s[1] | s[2]) & en[0];
    tx = s[3] & en[1];
    ms = s[4] & en[3];
    if (ls)      return {3'd3, 1'b0};
    else if (rx) return {(s[1] ? 3'd2 : 3'd6), 1'b0};
    else if (tx) return {3'd1, 1'b0};
    else if (ms) return {3'd0, 1'b0};
    else         return 4'b0001;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] mdm;
    rst_n = 1'b0;
    irq_en = 4'h0;
    rx_level_hit = 0; rx_char_timeout = 0; tx_space_hit = 0;
    rx_data_ready = 0; rx_overrun = 0; rx_parity_err = 0; rx_frame_err = 0; rx_break = 0;
    tx_hold_empty = 0; tx_shift_empty = 0; rx_fifo_err = 0;
    modem_in = 4'h0; status_rd = 0;
    step(); step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    chk("R9 reset word", {8'h0, status_word}, 32'h00F001);
    chk("R1 reset irq_n", {31'h0, irq_n}, 32'h1);

    // R1 R2 R3 R4 sweep
    mdm = 4'h0;
    for (int en = 0; en < 16; en++) begin
      for (int s = 0; s < 32; s++) begin
        logic [4:0] sv;
        logic [3:0] e;
        sv = s[4:0];
        irq_en = en[3:0];
        rx_level_hit = sv[1]; rx_char_timeout = sv[2]; tx_space_hit = sv[3];
        rx_overrun = sv[0];
        if (sv[4]) begin mdm[0] = ~mdm[0]; modem_in = mdm; end
        step();
        rx_overrun = 1'b0;
        e = exp_low(en[3:0], sv);
        chk("R3 R4 id/pending", {28'h0, status_word[3:0]}, {28'h0, e});
        chk("R1 irq_n", {31'h0, irq_n}, {31'h0, e[0]});
        rx_level_hit = 0; rx_char_timeout = 0; tx_space_hit = 0;
        do_read();
      end
    end
    irq_en = 4'hF;

    // R5 live levels
    rx_data_ready = 1; tx_hold_empty = 1; tx_shift_empty = 1; rx_fifo_err = 1;
    #1;
    chk("R5 live levels", {24'h0, status_word[23:16]}, 32'hE1);
    rx_data_ready = 0; tx_hold_empty = 0; tx_shift_empty = 0; rx_fifo_err = 0;

    // R5 R6 each error bit position, sticky then cleared
    for (int b = 0; b < 4; b++) begin
      {rx_break, rx_frame_err, rx_parity_err, rx_overrun} = 4'b1 << b;
      step();
      {rx_break, rx_frame_err, rx_parity_err, rx_overrun} = 4'b0;
      step();
      chk("R6 sticky error bit", {24'h0, status_word[23:16]}, 32'h2 << b);
      chk("R2 line id", {29'h0, status_word[3:1]}, 32'd3);
      do_read();
      chk("R6 cleared by read", {24'h0, status_word[23:16]}, 32'h0);
    end

    // R6 set wins over read
    rx_parity_err = 1; status_rd = 1;
    step();
    rx_parity_err = 0; status_rd = 0;
    chk("R6 set wins", {31'h0, status_word[18]}, 32'h1);
    do_read();

    // R7 R8 each modem input
    for (int b = 0; b < 4; b++) begin
      mdm[b] = ~mdm[b];
      modem_in = mdm;
      #1;
      chk("R7 sampled delay", {28'h0, status_word[15:12]}, {28'h0, ~(mdm ^ (4'b1 << b))});
      step();
      chk("R8 delta bit", {28'h0, status_word[11:8]}, 32'h1 << b);
      chk("R7 inverted level", {28'h0, status_word[15:12]}, {28'h0, ~mdm});
      do_read();
      chk("R8 delta cleared", {28'h0, status_word[11:8]}, 32'h0);
    end
    // R8 change during read wins
    mdm[2] = ~mdm[2]; modem_in = mdm; status_rd = 1;
    step();
    status_rd = 0;
    chk("R8 set wins", {28'h0, status_word[11:8]}, 32'h4);
    do_read();
    chk("R9 gap zero", {28'h0, status_word[7:4]}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule